// File: doc/BRIEF.md
# Prescaled GPIO Input Debouncer

This block cleans up the GPIO input pins before they reach the interrupt detector. One programmable prescaler divides the peripheral clock into a sample tick, and every pin shares that tick. Each pin has its own enable bit. When the bit is set, a change on the pin reaches the output only after it has been seen on two consecutive ticks. When the bit is clear, the pin passes straight through from its synchronizer.

The filtered vector feeds only the interrupt path. Plain data reads of the pins do not pass through this block, so debouncing matters only when interrupts are in use. Software programs the block through two word registers. One holds the per-pin enables and the other holds the 24-bit prescale divisor. Both registers read back through a simple combinational read port.

Top module: `gpio_debounce`

## Requirements
- R1: After reset the enable register and the prescale register read 0, and every filtered output is 0.
- R2: The enable register is at byte address 0x40. Bit i enables filtering on pin i. It reads back the written value in bits [NPINS-1:0], and the bits above read 0.
- R3: The prescale register is at byte address 0x44 and is 24 bits wide. Bits [23:0] of the written word are stored, and bits [31:24] read 0.
- R4: With a prescale value P of 2 or more, a tick occurs once every P clock cycles. With P equal to 0 or 1, a tick occurs on every cycle except the cycle of a prescale write.
- R5: A write to the prescale register restarts the divider from zero, so the first tick follows the edge of the write by exactly P edges when P is 2 or more.
- R6: An enabled pin changes its filtered output only on a tick where the synchronized input equals the value sampled on the previous tick. Suppose a pin change is presented together with a prescale write, and the edge of that write is counted as edge 0. The output then shows the new value after edge 2P when P is 2 or more, and after edge 3 when P is 0 or 1.
- R7: On an enabled pin, a pulse that lies between two ticks never reaches the filtered output.
- R8: Every pin passes through a two-stage synchronizer. A pin whose enable bit is clear shows a change after edge 1, counting the capturing edge as edge 0.
- R9: Pins are independent. A pin whose input does not change keeps its filtered value, whatever the enable bits or the other pins do.
- R10: A write to any address other than 0x40 or 0x44 changes neither register. A read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Raw asynchronous GPIO inputs |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Byte address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pin_filt | output | NPINS | Filtered or bypassed pin values toward the interrupt detector |

## Verification
The filter is swept over prescale values from 0 to 16. For each value it is tried with all pins filtered, with none filtered, and with a mixed enable mask, and each time a different set of pins toggles. This pattern separates the per-pin latency of the filtered path from that of the bypass path, and it shows the divider period and the restart on write. Pins that do not toggle expose any crosstalk between pins. A short pulse that falls between two ticks checks that glitches are rejected. Register access is tried with over-wide writes and with an unmapped address to check the field widths and the address decode.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 8;
    localparam int SYNC_STAGES = 2;
    localparam logic [ADDR_W-1:0] ADDR_ENABLE   = 8'h40;
    localparam logic [ADDR_W-1:0] ADDR_PRESCALE = 8'h44;
endpackage

// File: rtl/dbnc_prescaler.sv
module dbnc_prescaler #(
    parameter int PRE_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] pre_val,
    input  logic             restart,
    output logic             tick
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    at_limit;

    always_comb begin
        st_d     = st_q;
        at_limit = (pre_val <= PRE_W'(1)) || (st_q.cnt == pre_val - PRE_W'(1));
        tick     = !restart && at_limit;
        if (restart || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stage;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.stage = {st_q.stage[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.stage[STAGES-1];
endmodule

// File: rtl/dbnc_filter.sv
module dbnc_filter #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [NPINS-1:0] sync_in,
    input  logic [NPINS-1:0] en,
    output logic [NPINS-1:0] pin_filt
);
    typedef struct packed {
        logic sample;
        logic held;
    } pin_st_t;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        pin_st_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (tick) begin
                st_d.sample = sync_in[g];
                if (sync_in[g] == st_q.sample) begin
                    st_d.held = sync_in[g];
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign pin_filt[g] = en[g] ? st_q.held : sync_in[g];
    end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce
    import dbnc_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int PRE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPINS-1:0]    pin_in,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [NPINS-1:0]    pin_filt
);
    typedef struct packed {
        logic [NPINS-1:0] en;
        logic [PRE_W-1:0] pre;
    } regs_t;

    regs_t            regs_d, regs_q;
    logic             hit_en, hit_pre, pre_wr, tick;
    logic [NPINS-1:0] sync_q;
    logic [NPINS-1:0] en_q;
    logic [PRE_W-1:0] pre_q;

    assign hit_en  = (reg_addr == ADDR_ENABLE);
    assign hit_pre = (reg_addr == ADDR_PRESCALE);
    assign pre_wr  = reg_wr && hit_pre;
    assign en_q    = regs_q.en;
    assign pre_q   = regs_q.pre;

    always_comb begin
        regs_d = regs_q;
        if (reg_wr && hit_en) begin
            regs_d.en = reg_wdata[NPINS-1:0];
        end
        if (pre_wr) begin
            regs_d.pre = reg_wdata[PRE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        if (hit_en) begin
            reg_rdata = DATA_W'(regs_q.en);
        end else if (hit_pre) begin
            reg_rdata = DATA_W'(regs_q.pre);
        end else begin
            reg_rdata = '0;
        end
    end

    dbnc_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (sync_q)
    );

    dbnc_prescaler #(.PRE_W(PRE_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .pre_val (regs_q.pre),
        .restart (pre_wr),
        .tick    (tick)
    );

    dbnc_filter #(.NPINS(NPINS)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .sync_in  (sync_q),
        .en       (regs_q.en),
        .pin_filt (pin_filt)
    );
endmodule

// File: rtl/dbnc_chk.sv
module dbnc_chk
    import dbnc_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int PRE_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [NPINS-1:0]  en_q,
    input logic [PRE_W-1:0]  pre_q,
    input logic [NPINS-1:0]  sync_q,
    input logic              tick,
    input logic [NPINS-1:0]  pin_filt
);
    logic pre_write;
    assign pre_write = reg_wr && (reg_addr == ADDR_PRESCALE);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_q == '0 && pre_q == '0 && pin_filt == '0));

    // R3
    pre_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_PRESCALE) |-> (reg_rdata[DATA_W-1:PRE_W] == '0));

    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pre_q >= PRE_W'(2)) |=> !tick);

    // R4
    fast_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_q <= PRE_W'(1) && !pre_write) |-> tick);

    // R5
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_write && reg_wdata[PRE_W-1:0] >= PRE_W'(2)) |=> !tick);

    // R6
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (((pin_filt ^ $past(pin_filt)) & en_q & $past(en_q)) == '0));

    // R6
    confirm_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ((((pin_filt ^ $past(pin_filt)) & en_q & $past(en_q))
                   & (pin_filt ^ $past(sync_q))) == '0));
endmodule

bind gpio_debounce dbnc_chk #(.NPINS(NPINS), .PRE_W(PRE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .en_q      (en_q),
    .pre_q     (pre_q),
    .sync_q    (sync_q),
    .tick      (tick),
    .pin_filt  (pin_filt)
);

// File: tb/tb_gpio_debounce.sv
module tb_gpio_debounce;
    localparam int CLK_PERIOD = 10;
    localparam int NPINS      = 8;
    localparam int PRE_W      = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NPINS-1:0] pin_in = '0;
    logic             reg_wr = 1'b0;
    logic [7:0]       reg_addr = 8'h00;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic [NPINS-1:0] pin_filt;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    logic [NPINS-1:0] cur = '0;

    gpio_debounce #(.NPINS(NPINS), .PRE_W(PRE_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_filt  (pin_filt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Present a pin change together with a prescale write; measure per-pin latency.
    task automatic run_step(input int p, input logic [NPINS-1:0] en, input logic [NPINS-1:0] nxt);
        int first_k [NPINS];
        bit stray   [NPINS];
        int lim;
        logic [NPINS-1:0] old;
        old = cur;
        lim = 2 * p + 8;
        for (int i = 0; i < NPINS; i++) begin first_k[i] = -1; stray[i] = 1'b0; end
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h44; reg_wdata = 32'(p); pin_in = nxt;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        check(pin_filt == old, "R6 R8 no early change", pin_filt, old);
        for (int k = 1; k <= lim; k++) begin
            @(posedge clk);
            @(negedge clk);
            for (int i = 0; i < NPINS; i++) begin
                if (nxt[i] != old[i]) begin
                    if (first_k[i] < 0 && pin_filt[i] == nxt[i]) first_k[i] = k;
                end else if (pin_filt[i] != old[i]) begin
                    stray[i] = 1'b1;
                end
            end
        end
        for (int i = 0; i < NPINS; i++) begin
            int exp_k;
            if (nxt[i] == old[i]) begin
                check(!stray[i], "R9 unchanged pin held", stray[i], 0);
            end else if (en[i]) begin
                exp_k = (p <= 1) ? 3 : 2 * p;
                check(first_k[i] == exp_k, "R4 R5 R6 filtered latency", first_k[i], exp_k);
            end else begin
                check(first_k[i] == 1, "R8 bypass latency", first_k[i], 1);
            end
        end
        cur = nxt;
        settle(2 * p + 8);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [NPINS-1:0] masks   [3];
        logic [NPINS-1:0] toggles [3];
        int pvals [7];
        masks   = '{8'hFF, 8'h00, 8'hA5};
        toggles = '{8'hFF, 8'h3C, 8'h81};
        pvals   = '{0, 1, 2, 3, 5, 7, 16};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1
        rd_reg(8'h40, rd); check(rd == 0, "R1 enable reset", rd, 0);
        rd_reg(8'h44, rd); check(rd == 0, "R1 prescale reset", rd, 0);
        check(pin_filt == '0, "R1 filtered reset", pin_filt, 0);

        // R2, R3: field widths
        wr_reg(8'h40, 32'hFFFF_FF5A);
        rd_reg(8'h40, rd); check(rd == 32'h5A, "R2 enable readback", rd, 32'h5A);
        wr_reg(8'h44, 32'hFFFF_FFFF);
        rd_reg(8'h44, rd); check(rd == 32'h00FF_FFFF, "R3 prescale width", rd, 32'h00FF_FFFF);

        // R10: unmapped address
        wr_reg(8'h48, 32'h0000_0011);
        rd_reg(8'h40, rd); check(rd == 32'h5A, "R10 enable untouched", rd, 32'h5A);
        rd_reg(8'h44, rd); check(rd == 32'h00FF_FFFF, "R10 prescale untouched", rd, 32'h00FF_FFFF);
        rd_reg(8'h48, rd); check(rd == 0, "R10 unmapped reads zero", rd, 0);

        wr_reg(8'h44, 32'h0);
        settle(8);

        // R4 R5 R6 R8 R9 sweep
        foreach (pvals[pi]) begin
            for (int m = 0; m < 3; m++) begin
                wr_reg(8'h40, 32'(masks[m]));
                settle(4);
                run_step(pvals[pi], masks[m], cur ^ toggles[m]);
            end
        end

        // R7: pulse between ticks is rejected (P = 4, pulse two cycles)
        wr_reg(8'h40, 32'hFF);
        wr_reg(8'h44, 32'd4);
        pin_in = '0; cur = '0;
        settle(20);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h44; reg_wdata = 32'd4; pin_in = '1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        @(posedge clk);
        @(negedge clk);
        pin_in = '0;
        begin
            bit seen;
            seen = 1'b0;
            for (int k = 0; k < 24; k++) begin
                @(negedge clk);
                if (pin_filt != '0) seen = 1'b1;
            end
            check(!seen, "R7 glitch rejected", seen, 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule